// File: doc/BRIEF.md
# Long-Latency Unit Occupancy Controller

This block is the timing shell around a long-latency arithmetic unit such as a floating-point divider. Decode offers an operation with a destination register tag and a payload. The shell holds the operation for a fixed number of execution cycles and then presents the tag and the unchanged payload for one cycle, so that writeback can use them. The arithmetic itself sits outside the shell. The payload only travels with the operation.

The execution time `LATENCY` is cut into `LATENCY/II` equal sub-stages of `II` cycles each. With `II == LATENCY` the unit is unpipelined and takes one operation at a time. With `1 < II < LATENCY` it is partially pipelined, and a new operation can enter every `II` cycles. One cycle ahead, the shell tells decode whether an operation offered in the next cycle will be taken. Decode must hold the instruction while that signal is low. For two operations back to back with no stall in unpipelined mode, instantiate two shells side by side and steer alternate operations to each.

Each sub-stage is a slot state machine with two states. `SL_IDLE` moves to `SL_BUSY` on a load. `SL_BUSY` counts `II` cycles, then either reloads (stays `SL_BUSY`) or returns to `SL_IDLE`. The issue gate has two states. `GT_OPEN` moves to `GT_HOLD` on an accepted issue. `GT_HOLD` counts down the first sub-stage and moves back to `GT_OPEN` when it ends, unless a new issue is accepted in that same cycle. The parameters must satisfy `II >= 2` and `LATENCY % II == 0`. Elaboration stops with an error otherwise.

Top module: `mcfu_occupancy`

## Requirements
- R1: A synchronous reset discards every operation in flight. While `rst` is high, and in the first cycle after it falls, `done_o` is 0. With `issue_i` low, `rdy_nxt_o` is 1 in those cycles.
- R2: An operation accepted in cycle t raises `done_o` in exactly cycle t+LATENCY+1.
- R3: In the `done_o` cycle, `done_tag_o` and `done_pay_o` equal the tag and payload offered with the accepted issue.
- R4: An `issue_i` in cycle t is accepted only if `rdy_nxt_o` was 1 in cycle t-1. In the first cycle after reset it is always accepted. An issue that is not accepted is ignored and never produces a `done_o`.
- R5: `rdy_nxt_o` in cycle t is 1 exactly when no issue is accepted in cycle t and t+1 is at least II cycles after the most recent accepted issue.
- R6: In unpipelined mode (II = LATENCY = 6), when issue is held high continuously, successive operations are accepted 6 cycles apart.
- R7: In partially pipelined mode (II = 2, LATENCY = 6), when issue is held high continuously, successive operations are accepted 2 cycles apart, which is one stall cycle each.
- R8: `done_o` is a single-cycle pulse. Two `done_o` pulses are at least II cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| issue_i | input | 1 | Decode offers an operation this cycle |
| issue_tag_i | input | TAG_W | Destination register tag of the offered operation |
| issue_pay_i | input | PAY_W | Payload carried with the offered operation |
| rdy_nxt_o | output | 1 | An issue offered next cycle will be accepted |
| done_o | output | 1 | One-cycle completion pulse |
| done_tag_o | output | TAG_W | Tag of the completing operation |
| done_pay_o | output | PAY_W | Payload of the completing operation |

## Verification
Suppose the issue gate's countdown slips by one cycle. `rdy_nxt_o` then rises a cycle early or late, and this shows at the ports in the cycle after the next accepted issue. An early rise also lets a new operation overtake one still in the first sub-stage, which corrupts the tag or payload at `done_o` LATENCY+1 cycles later. A slot counter that is off by one moves `done_o` away from cycle t+LATENCY+1, so every completion is compared against its exact cycle. A lost or doubled handoff between slots appears as a missing or extra `done_o` within one operation latency.

// File: rtl/mcfu_pkg.sv
package mcfu_pkg;

    typedef enum logic {
        SL_IDLE = 1'b0,
        SL_BUSY = 1'b1
    } slot_state_e;

    typedef enum logic {
        GT_OPEN = 1'b0,
        GT_HOLD = 1'b1
    } gate_state_e;

endpackage

// File: rtl/mcfu_slot.sv
module mcfu_slot
    import mcfu_pkg::*;
#(
    parameter int II    = 2,
    parameter int TAG_W = 5,
    parameter int PAY_W = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             load_i,
    input  logic [TAG_W-1:0] tag_i,
    input  logic [PAY_W-1:0] pay_i,
    output logic             last_o,
    output logic [TAG_W-1:0] tag_o,
    output logic [PAY_W-1:0] pay_o
);
    localparam int CW = (II > 1) ? $clog2(II) : 1;
    localparam logic [CW-1:0] CNT_LAST = CW'(II - 1);

    slot_state_e      state_q, state_d;
    logic [CW-1:0]    cnt_q, cnt_d;
    logic             take;
    logic [TAG_W-1:0] tag_q;
    logic [PAY_W-1:0] pay_q;

    always_comb begin
        state_d = state_q;
        cnt_d   = cnt_q;
        take    = 1'b0;
        unique case (state_q)
            SL_IDLE: begin
                if (load_i) begin
                    state_d = SL_BUSY;
                    cnt_d   = '0;
                    take    = 1'b1;
                end
            end
            SL_BUSY: begin
                if (cnt_q == CNT_LAST) begin
                    if (load_i) begin
                        cnt_d = '0;
                        take  = 1'b1;
                    end else begin
                        state_d = SL_IDLE;
                    end
                end else begin
                    cnt_d = cnt_q + 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= SL_IDLE;
            cnt_q   <= '0;
            tag_q   <= '0;
            pay_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
            if (take) begin
                tag_q <= tag_i;
                pay_q <= pay_i;
            end
        end
    end

    always_comb begin
        last_o = (state_q == SL_BUSY) && (cnt_q == CNT_LAST);
        tag_o  = tag_q;
        pay_o  = pay_q;
    end

endmodule

// File: rtl/mcfu_issue_gate.sv
module mcfu_issue_gate
    import mcfu_pkg::*;
#(
    parameter int II = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic issue_i,
    output logic accept_o,
    output logic rdy_nxt_o
);
    localparam int CW = (II > 1) ? $clog2(II) : 1;
    localparam logic [CW-1:0] REM_FULL = CW'(II - 1);
    localparam logic [CW-1:0] REM_ONE  = CW'(1);

    gate_state_e   state_q, state_d;
    logic [CW-1:0] rem_q, rem_d;
    logic          grant_q;
    logic          accept;

    assign accept = issue_i && grant_q && !rst;

    always_comb begin
        state_d = state_q;
        rem_d   = rem_q;
        unique case (state_q)
            GT_OPEN: begin
                if (accept) begin
                    state_d = GT_HOLD;
                    rem_d   = REM_FULL;
                end
            end
            GT_HOLD: begin
                if (accept) begin
                    rem_d = REM_FULL;
                end else if (rem_q == '0) begin
                    state_d = GT_OPEN;
                end else begin
                    rem_d = rem_q - 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= GT_OPEN;
            rem_q   <= '0;
            grant_q <= 1'b1;
        end else begin
            state_q <= state_d;
            rem_q   <= rem_d;
            grant_q <= rdy_nxt_o;
        end
    end

    always_comb begin
        accept_o  = accept;
        rdy_nxt_o = !accept && ((state_q == GT_OPEN) || (rem_q <= REM_ONE));
    end

endmodule

// File: rtl/mcfu_occupancy.sv
module mcfu_occupancy
    import mcfu_pkg::*;
#(
    parameter int LATENCY = 6,
    parameter int II      = 2,
    parameter int TAG_W   = 5,
    parameter int PAY_W   = 32
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue_i,
    input  logic [TAG_W-1:0] issue_tag_i,
    input  logic [PAY_W-1:0] issue_pay_i,
    output logic             rdy_nxt_o,
    output logic             done_o,
    output logic [TAG_W-1:0] done_tag_o,
    output logic [PAY_W-1:0] done_pay_o
);
    localparam int NSTG = (II > 0) ? (LATENCY / II) : 1;

    generate
        if (II < 2 || (LATENCY % II) != 0) begin : g_bad_cfg
            $error("mcfu_occupancy: II must be >= 2 and divide LATENCY");
        end
    endgenerate

    logic             accept;
    logic [NSTG:0]    load;
    logic [NSTG-1:0]  last;
    logic [TAG_W-1:0] tag_v [NSTG+1];
    logic [PAY_W-1:0] pay_v [NSTG+1];

    mcfu_issue_gate #(.II(II)) u_gate (
        .clk       (clk),
        .rst       (rst),
        .issue_i   (issue_i),
        .accept_o  (accept),
        .rdy_nxt_o (rdy_nxt_o)
    );

    assign load[0]  = accept;
    assign tag_v[0] = issue_tag_i;
    assign pay_v[0] = issue_pay_i;

    genvar s;
    generate
        for (s = 0; s < NSTG; s++) begin : g_stage
            mcfu_slot #(.II(II), .TAG_W(TAG_W), .PAY_W(PAY_W)) u_slot (
                .clk    (clk),
                .rst    (rst),
                .load_i (load[s]),
                .tag_i  (tag_v[s]),
                .pay_i  (pay_v[s]),
                .last_o (last[s]),
                .tag_o  (tag_v[s+1]),
                .pay_o  (pay_v[s+1])
            );
            assign load[s+1] = last[s];
        end
    endgenerate

    logic             done_q;
    logic [TAG_W-1:0] dtag_q;
    logic [PAY_W-1:0] dpay_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            done_q <= 1'b0;
            dtag_q <= '0;
            dpay_q <= '0;
        end else begin
            done_q <= load[NSTG];
            if (load[NSTG]) begin
                dtag_q <= tag_v[NSTG];
                dpay_q <= pay_v[NSTG];
            end
        end
    end

    always_comb begin
        done_o     = done_q;
        done_tag_o = dtag_q;
        done_pay_o = dpay_q;
    end

endmodule

// File: rtl/mcfu_occupancy_chk.sv
module mcfu_occupancy_chk #(
    parameter int II = 2
) (
    input logic clk,
    input logic rst,
    input logic accept,
    input logic rdy_nxt_o,
    input logic done_o
);
    logic        seen_done;
    logic [15:0] gap;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_done <= 1'b0;
            gap       <= '0;
        end else if (done_o) begin
            seen_done <= 1'b1;
            gap       <= 16'd1;
        end else if (gap != 16'hFFFF) begin
            gap <= gap + 16'd1;
        end
    end

    AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !done_o);  // R1

    AST_ACCEPT_NEEDS_GRANT: assert property (@(posedge clk) disable iff (rst)
        (accept && !$past(rst)) |-> $past(rdy_nxt_o));  // R4

    AST_NO_GRANT_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
        accept |-> !rdy_nxt_o);  // R5

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);  // R8

    AST_DONE_SPACING: assert property (@(posedge clk) disable iff (rst)
        (done_o && seen_done) |-> (gap >= 16'(II)));  // R8

endmodule

bind mcfu_occupancy mcfu_occupancy_chk #(.II(II)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .accept    (accept),
    .rdy_nxt_o (rdy_nxt_o),
    .done_o    (done_o)
);

// File: tb/mcfu_occupancy_tb.sv
`timescale 1ns/1ps
module mcfu_occupancy_tb;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        issue = 1'b0;
    logic [4:0]  itag = '0;
    logic [31:0] ipay = '0;

    logic        rdy_p, done_p, rdy_u, done_u;
    logic [4:0]  dtag_p, dtag_u;
    logic [31:0] dpay_p, dpay_u;

    always #5 clk = ~clk;

    mcfu_occupancy #(.LATENCY(LAT), .II(2)) u_dut (
        .clk(clk), .rst(rst), .issue_i(issue), .issue_tag_i(itag), .issue_pay_i(ipay),
        .rdy_nxt_o(rdy_p), .done_o(done_p), .done_tag_o(dtag_p), .done_pay_o(dpay_p));

    mcfu_occupancy #(.LATENCY(LAT), .II(LAT)) u_dut_unp (
        .clk(clk), .rst(rst), .issue_i(issue), .issue_tag_i(itag), .issue_pay_i(ipay),
        .rdy_nxt_o(rdy_u), .done_o(done_u), .done_tag_o(dtag_u), .done_pay_o(dpay_u));

    int n_chk = 0;
    int n_fail = 0;
    int cyc = 0;
    int last_acc [2];
    bit pdone [2];
    bit          ev [2][64];
    logic [4:0]  et [2][64];
    logic [31:0] ep [2][64];

    function automatic int ii_of(input int u);
        return (u == 0) ? 2 : LAT;
    endfunction

    function automatic bit will_accept(input int u, input bit iss, input int c);
        return iss && ((c - last_acc[u]) >= ii_of(u));
    endfunction

    function automatic bit exp_rdy(input int u, input bit acc, input int c);
        return !acc && ((c + 1 - last_acc[u]) >= ii_of(u));
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s cycle %0d: actual %0d expected %0d", req, what, cyc, act, exp);
        end
    endtask

    task automatic clear_model();
        for (int u = 0; u < 2; u++) begin
            last_acc[u] = cyc - 100;
            pdone[u] = 1'b0;
            for (int k = 0; k < 64; k++) ev[u][k] = 1'b0;
        end
    endtask

    task automatic step(input bit iss, input logic [4:0] tg, input logic [31:0] pl);
        @(negedge clk);
        issue = iss; itag = tg; ipay = pl;
        #1;
        for (int u = 0; u < 2; u++) begin
            bit acc, r, d;
            logic [4:0] t;
            logic [31:0] p;
            int slot;
            r = (u == 0) ? rdy_p : rdy_u;
            d = (u == 0) ? done_p : done_u;
            t = (u == 0) ? dtag_p : dtag_u;
            p = (u == 0) ? dpay_p : dpay_u;
            acc = will_accept(u, iss, cyc);
            chk(r == exp_rdy(u, acc, cyc), (u == 0) ? "R7 R5" : "R6 R5", "rdy_nxt",
                r, exp_rdy(u, acc, cyc));
            slot = cyc % 64;
            chk(d == ev[u][slot], "R2 R4", "done", d, ev[u][slot]);
            if (ev[u][slot]) begin
                chk(t == et[u][slot], "R3", "tag", t, et[u][slot]);
                chk(p == ep[u][slot], "R3", "payload", p, ep[u][slot]);
            end
            chk(!(d && pdone[u]), "R8", "pulse", d, 0);
            pdone[u] = d;
            ev[u][slot] = 1'b0;
            if (acc) begin
                last_acc[u] = cyc;
                slot = (cyc + LAT + 1) % 64;
                ev[u][slot] = 1'b1;
                et[u][slot] = tg;
                ep[u][slot] = pl;
            end
        end
        cyc++;
    endtask

    task automatic do_reset(input int n);
        @(negedge clk);
        rst = 1'b1; issue = 1'b0;
        repeat (n) begin
            @(negedge clk);
            #1;
            chk(done_p == 1'b0 && done_u == 1'b0, "R1", "done in reset", done_p | done_u, 0);
        end
        chk(rdy_p == 1'b1 && rdy_u == 1'b1, "R1", "rdy in reset", rdy_p & rdy_u, 1);
        rst = 1'b0;
        #1;
        chk(done_p == 1'b0 && done_u == 1'b0, "R1", "done after reset", done_p | done_u, 0);
        cyc += 10;
        clear_model();
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin : main
        void'($urandom(32'd24680));
        do_reset(3);
        // R6 R7: issue held high, tags count up
        for (int i = 0; i < 24; i++) step(1'b1, 5'(i), 32'hA000_0000 + i);
        for (int i = 0; i < 12; i++) step(1'b0, '0, '0);
        // mid-flight reset discards operations (R1)
        step(1'b1, 5'd7, 32'hDEAD_BEEF);
        step(1'b0, '0, '0);
        do_reset(2);
        for (int i = 0; i < 10; i++) step(1'b0, '0, '0);
        // R4: issue exactly on previous unpipelined grant
        for (int i = 0; i < 200; i++) step(rdy_u, 5'($urandom), $urandom);
        // constrained random mix
        for (int i = 0; i < 3000; i++) begin
            bit iss;
            iss = ($urandom % 100) < 45;
            step(iss, 5'($urandom), $urandom);
        end
        for (int i = 0; i < 12; i++) step(1'b0, '0, '0);
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule